// File: doc/BRIEF.md
# Programmable Vertical Sync and Field Generator

This block produces the vertical sync level and the field flag of an interlaced video stream. It counts lines and pixels internally from one-cycle horizontal sync begin and end markers. It follows 525-line or 625-line timing, chosen by a standard select. For each standard it can move three events away from their nominal lines: the start of vertical sync, the end of vertical sync and the field toggle. Each event takes a signed 5-bit line offset plus an optional extra line of delay that applies in one field only.

For each field, the start and the end of the sync pulse can each be placed at the line start or at mid-line. The line start itself can refer to either the leading or the trailing horizontal sync marker, and the sync output can be inverted. A fixed mode ignores all offsets and uses nominal positions. All configuration is held in shadow registers that load only at the start of line 1. A frame in progress is never cut short.

Top module: `vsf_gen`

## Requirements
- R1: A line start is the clock on which the selected marker is high: `hsEnd` when the reference select is 0, `hsBegin` when it is 1. The line count is 0 after reset. It moves on each line start to the next value in 1..N, wrapping N to 1 (N = 525 when the standard select is 0, 625 when it is 1), and is visible on `lineDbg`.
- R2: The mid-line point of a line is the cycle in which the number of clocks since its line start equals LINE_PIX/2 (rounded down) for the active standard. A mid-line transition is registered at the end of that cycle.
- R3: Each control byte holds a magnitude in bits [4:0], a subtract flag in bit 5, an odd-field delay in bit 6 and an even-field delay in bit 7. In programmable mode, the target line is the nominal line plus or minus the magnitude, plus one if the delay bit of that field is set, wrapped into 1..N. The odd-field nominal is the first value of each pair (sync start 1/263, end 10/272, field 4/266 for 525; start 623/311, end 5/318, field 1/313 for 625).
- R4: The sync start happens at mid-line when the field's start-position bit is 0 and at the line start when it is 1. After reset the odd bit is 0 and the even bit is 1.
- R5: The sync end happens at mid-line when the field's end-position bit is 0 and at the line start when it is 1. Both bits are 0 after reset.
- R6: `fieldOut` goes to 1 at the line start of the even-field toggle line and to 0 at the line start of the odd-field toggle line. It changes at no other time.
- R7: With the mode bit at 0, sync start, sync end and field toggle occur at the line start of their nominal lines. Offsets, delay bits and position bits have no effect. The mode bit is 1 after reset.
- R8: `vsOut` is the sync level when the invert bit is 0 and its complement when it is 1. The invert bit is 0 after reset.
- R9: Configuration inputs, the standard and reference selects included, take effect only from the clock after a line start that enters line 1. Events on that same clock still use the previous settings.
- R10: During and right after reset, `vsOut`, `fieldOut` and `lineDbg` are 0.
- R11: When a sync start and a sync end fall on the same clock, the end wins and the sync level is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| std625 | input | 1 | Standard select: 0 = 525 lines, 1 = 625 lines |
| hsBegin | input | 1 | One-cycle marker at the start of horizontal sync |
| hsEnd | input | 1 | One-cycle marker at the end of horizontal sync |
| progMode | input | 1 | 1 = programmable positions, 0 = fixed nominal positions |
| refBegin | input | 1 | Line-start reference: 0 = `hsEnd`, 1 = `hsBegin` |
| begStartOdd | input | 1 | Odd-field sync start at line start (1) or mid-line (0) |
| begStartEven | input | 1 | Even-field sync start at line start (1) or mid-line (0) |
| endStartOdd | input | 1 | Odd-field sync end at line start (1) or mid-line (0) |
| endStartEven | input | 1 | Even-field sync end at line start (1) or mid-line (0) |
| invertVs | input | 1 | Invert the sync output |
| vsBeg525 | input | 8 | Sync start control byte, 525-line timing |
| vsEnd525 | input | 8 | Sync end control byte, 525-line timing |
| fldTog525 | input | 8 | Field toggle control byte, 525-line timing |
| vsBeg625 | input | 8 | Sync start control byte, 625-line timing |
| vsEnd625 | input | 8 | Sync end control byte, 625-line timing |
| fldTog625 | input | 8 | Field toggle control byte, 625-line timing |
| vsOut | output | 1 | Vertical sync output |
| fieldOut | output | 1 | Field flag, 1 in the even field |
| lineDbg | output | 10 | Current line count |

## Verification
The hardest situations to reach are at the frame boundary. A new setting lands while a pulse is in progress, a target wraps past line N into the next frame, or a start and an end share one clock. The stimulus produces them by changing the configuration at arbitrary points in the frame, including mid-pulse. It uses offsets that push targets below 1 and above N, and it programs a start and an end onto the same mid-line point. A line-accurate model in the bench, driven by the same markers, is compared with the outputs on every clock across whole frames of both standards.

// File: rtl/vsf_pkg.sv
`timescale 1ns/1ps
package vsf_pkg;
  localparam int LINE_W = 10;

  // one line-position control: [7] even delay, [6] odd delay, [5] subtract, [4:0] magnitude
  typedef struct packed {
    logic       dlyEven;
    logic       dlyOdd;
    logic       neg;
    logic [4:0] mag;
  } lineCtl_t;

  typedef struct packed {
    logic     progMode;
    logic     refBegin;
    logic     begStartOdd;
    logic     begStartEven;
    logic     endStartOdd;
    logic     endStartEven;
    logic     invert;
    logic     std625;
    lineCtl_t beg525;
    lineCtl_t end525;
    lineCtl_t fld525;
    lineCtl_t beg625;
    lineCtl_t end625;
    lineCtl_t fld625;
  } vsfCfg_t;

  // strobes from the timing control to the edge datapath
  typedef struct packed {
    logic              startEv;
    logic              midEv;
    logic              frameLoad;
    logic [LINE_W-1:0] evLine;
  } tick_t;

  function automatic vsfCfg_t resetCfg();
    vsfCfg_t c;
    c = '0;
    c.progMode     = 1'b1;
    c.begStartEven = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/vsf_shadow.sv
`timescale 1ns/1ps
module vsf_shadow
  import vsf_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    load,
  input  vsfCfg_t cfgIn,
  output vsfCfg_t cfgAct
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cfgAct <= resetCfg();
    else if (load) cfgAct <= cfgIn;
  end
endmodule

// File: rtl/vsf_timing.sv
`timescale 1ns/1ps
module vsf_timing
  import vsf_pkg::*;
#(
  parameter int LINES_525    = 525,
  parameter int LINES_625    = 625,
  parameter int LINE_PIX_525 = 858,
  parameter int LINE_PIX_625 = 864
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsBegin,
  input  logic              hsEnd,
  input  logic              refBegin,
  input  logic              std625,
  output tick_t             tick,
  output logic [LINE_W-1:0] lineCnt
);
  localparam int MAX_PIX  = (LINE_PIX_525 > LINE_PIX_625) ? LINE_PIX_525 : LINE_PIX_625;
  localparam int PIX_W    = $clog2(MAX_PIX + 1);
  localparam int HALF_525 = LINE_PIX_525 / 2;
  localparam int HALF_625 = LINE_PIX_625 / 2;
  localparam logic [PIX_W-1:0] PIX_SAT = '1;

  logic [PIX_W-1:0]  pixCnt;
  logic [PIX_W-1:0]  halfPix;
  logic [LINE_W-1:0] totalLines;
  logic [LINE_W-1:0] nextLine;
  logic              lineStart;
  logic              midHit;

  always_comb begin
    lineStart  = refBegin ? hsBegin : hsEnd;
    totalLines = std625 ? LINE_W'(LINES_625) : LINE_W'(LINES_525);
    halfPix    = std625 ? PIX_W'(HALF_625) : PIX_W'(HALF_525);
    nextLine   = (lineCnt >= totalLines) ? LINE_W'(1) : lineCnt + LINE_W'(1);
    midHit     = !lineStart && (pixCnt == halfPix) && (lineCnt != '0);

    tick.startEv   = lineStart;
    tick.midEv     = midHit;
    tick.frameLoad = lineStart && (nextLine == LINE_W'(1));
    tick.evLine    = lineStart ? nextLine : lineCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineCnt <= '0;
    end else if (lineStart) begin
      pixCnt  <= '0;
      lineCnt <= nextLine;
    end else if (pixCnt != PIX_SAT) begin
      pixCnt  <= pixCnt + PIX_W'(1);
    end
  end
endmodule

// File: rtl/vsf_edge.sv
`timescale 1ns/1ps
module vsf_edge
  import vsf_pkg::*;
#(
  parameter int LINES_525   = 525,
  parameter int LINES_625   = 625,
  parameter int BEG_ODD_525 = 1,
  parameter int BEG_EVN_525 = 263,
  parameter int END_ODD_525 = 10,
  parameter int END_EVN_525 = 272,
  parameter int FLD_ODD_525 = 4,
  parameter int FLD_EVN_525 = 266,
  parameter int BEG_ODD_625 = 623,
  parameter int BEG_EVN_625 = 311,
  parameter int END_ODD_625 = 5,
  parameter int END_EVN_625 = 318,
  parameter int FLD_ODD_625 = 1,
  parameter int FLD_EVN_625 = 313
) (
  input  logic    clk,
  input  logic    rstN,
  input  tick_t   tick,
  input  vsfCfg_t cfg,
  output logic    vsLevel,
  output logic    fieldLevel
);
  localparam int NCTL = 3; // 0 = sync start, 1 = sync end, 2 = field toggle
  localparam int NOM_ODD_525[NCTL] = '{BEG_ODD_525, END_ODD_525, FLD_ODD_525};
  localparam int NOM_EVN_525[NCTL] = '{BEG_EVN_525, END_EVN_525, FLD_EVN_525};
  localparam int NOM_ODD_625[NCTL] = '{BEG_ODD_625, END_ODD_625, FLD_ODD_625};
  localparam int NOM_EVN_625[NCTL] = '{BEG_EVN_625, END_EVN_625, FLD_EVN_625};

  lineCtl_t          ctl     [NCTL];
  logic [LINE_W-1:0] tgtOdd  [NCTL];
  logic [LINE_W-1:0] tgtEven [NCTL];

  function automatic logic [LINE_W-1:0] placeLine(int nom, lineCtl_t c, logic addDly, int total);
    int t;
    t = nom + (c.neg ? -int'(c.mag) : int'(c.mag)) + (addDly ? 1 : 0);
    if (t < 1)          t = t + total;
    else if (t > total) t = t - total;
    return LINE_W'(t);
  endfunction

  always_comb begin
    ctl[0] = cfg.std625 ? cfg.beg625 : cfg.beg525;
    ctl[1] = cfg.std625 ? cfg.end625 : cfg.end525;
    ctl[2] = cfg.std625 ? cfg.fld625 : cfg.fld525;
  end

  for (genvar k = 0; k < NCTL; k++) begin : g_target
    always_comb begin
      int nomOdd;
      int nomEven;
      int total;
      nomOdd  = cfg.std625 ? NOM_ODD_625[k] : NOM_ODD_525[k];
      nomEven = cfg.std625 ? NOM_EVN_625[k] : NOM_EVN_525[k];
      total   = cfg.std625 ? LINES_625 : LINES_525;
      if (cfg.progMode) begin
        tgtOdd[k]  = placeLine(nomOdd,  ctl[k], ctl[k].dlyOdd,  total);
        tgtEven[k] = placeLine(nomEven, ctl[k], ctl[k].dlyEven, total);
      end else begin
        tgtOdd[k]  = LINE_W'(nomOdd);
        tgtEven[k] = LINE_W'(nomEven);
      end
    end
  end

  // per-field choice of line start or mid-line; fixed mode always uses line start
  logic begOddEv, begEvenEv, endOddEv, endEvenEv;
  logic setVs, clrVs;

  always_comb begin
    begOddEv  = (cfg.progMode && !cfg.begStartOdd)  ? tick.midEv : tick.startEv;
    begEvenEv = (cfg.progMode && !cfg.begStartEven) ? tick.midEv : tick.startEv;
    endOddEv  = (cfg.progMode && !cfg.endStartOdd)  ? tick.midEv : tick.startEv;
    endEvenEv = (cfg.progMode && !cfg.endStartEven) ? tick.midEv : tick.startEv;
    setVs = (begOddEv  && tick.evLine == tgtOdd[0]) ||
            (begEvenEv && tick.evLine == tgtEven[0]);
    clrVs = (endOddEv  && tick.evLine == tgtOdd[1]) ||
            (endEvenEv && tick.evLine == tgtEven[1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vsLevel    <= 1'b0;
      fieldLevel <= 1'b0;
    end else begin
      if (clrVs)      vsLevel <= 1'b0;
      else if (setVs) vsLevel <= 1'b1;
      if (tick.startEv) begin
        if (tick.evLine == tgtEven[2])     fieldLevel <= 1'b1;
        else if (tick.evLine == tgtOdd[2]) fieldLevel <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vsf_gen.sv
`timescale 1ns/1ps
module vsf_gen
  import vsf_pkg::*;
#(
  parameter int LINES_525    = 525,
  parameter int LINES_625    = 625,
  parameter int LINE_PIX_525 = 858,
  parameter int LINE_PIX_625 = 864
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              std625,
  input  logic              hsBegin,
  input  logic              hsEnd,
  input  logic              progMode,
  input  logic              refBegin,
  input  logic              begStartOdd,
  input  logic              begStartEven,
  input  logic              endStartOdd,
  input  logic              endStartEven,
  input  logic              invertVs,
  input  logic [7:0]        vsBeg525,
  input  logic [7:0]        vsEnd525,
  input  logic [7:0]        fldTog525,
  input  logic [7:0]        vsBeg625,
  input  logic [7:0]        vsEnd625,
  input  logic [7:0]        fldTog625,
  output logic              vsOut,
  output logic              fieldOut,
  output logic [LINE_W-1:0] lineDbg
);
  vsfCfg_t cfgIn;
  vsfCfg_t cfgAct;
  tick_t   tick;
  logic    vsLevel;

  always_comb begin
    cfgIn.progMode     = progMode;
    cfgIn.refBegin     = refBegin;
    cfgIn.begStartOdd  = begStartOdd;
    cfgIn.begStartEven = begStartEven;
    cfgIn.endStartOdd  = endStartOdd;
    cfgIn.endStartEven = endStartEven;
    cfgIn.invert       = invertVs;
    cfgIn.std625       = std625;
    cfgIn.beg525       = vsBeg525;
    cfgIn.end525       = vsEnd525;
    cfgIn.fld525       = fldTog525;
    cfgIn.beg625       = vsBeg625;
    cfgIn.end625       = vsEnd625;
    cfgIn.fld625       = fldTog625;
  end

  vsf_shadow u_shadow (
    .clk   (clk),
    .rstN  (rstN),
    .load  (tick.frameLoad),
    .cfgIn (cfgIn),
    .cfgAct(cfgAct)
  );

  vsf_timing #(
    .LINES_525   (LINES_525),
    .LINES_625   (LINES_625),
    .LINE_PIX_525(LINE_PIX_525),
    .LINE_PIX_625(LINE_PIX_625)
  ) u_timing (
    .clk     (clk),
    .rstN    (rstN),
    .hsBegin (hsBegin),
    .hsEnd   (hsEnd),
    .refBegin(cfgAct.refBegin),
    .std625  (cfgAct.std625),
    .tick    (tick),
    .lineCnt (lineDbg)
  );

  vsf_edge #(
    .LINES_525(LINES_525),
    .LINES_625(LINES_625)
  ) u_edge (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .cfg       (cfgAct),
    .vsLevel   (vsLevel),
    .fieldLevel(fieldOut)
  );

  assign vsOut = vsLevel ^ cfgAct.invert;
endmodule

// File: rtl/vsf_gen_chk.sv
`timescale 1ns/1ps
module vsf_gen_chk
  import vsf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input tick_t             tick,
  input vsfCfg_t           cfgAct,
  input logic              vsLevel,
  input logic              fieldOut,
  input logic [LINE_W-1:0] lineDbg
);
  // R1: the line count only steps by one or restarts at 1
  a_r1_line_step: assert property (@(posedge clk) disable iff (!rstN)
    (lineDbg != $past(lineDbg)) |-> (lineDbg == LINE_W'(1) || lineDbg == $past(lineDbg) + LINE_W'(1)));

  // R2: the sync level moves only after a line-start or mid-line strobe
  a_r2_vs_on_event: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vsLevel) |-> $past(tick.startEv || tick.midEv));

  // R6: the field flag moves only after a line start
  a_r6_field_at_start: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fieldOut) |-> $past(tick.startEv));

  // R7: in fixed mode the sync level moves only at a line start
  a_r7_fixed_at_start: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(vsLevel) && !$past(cfgAct.progMode)) |-> $past(tick.startEv));

  // R9: active settings change only on a frame-load strobe
  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgAct) |-> $past(tick.frameLoad));
endmodule

bind vsf_gen vsf_gen_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .cfgAct  (cfgAct),
  .vsLevel (vsLevel),
  .fieldOut(fieldOut),
  .lineDbg (lineDbg)
);

// File: tb/vsf_gen_bench.sv
`timescale 1ns/1ps
module vsf_gen_bench;
  import vsf_pkg::*;

  localparam int PIX525 = 8;
  localparam int PIX625 = 10;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsBegin = 1'b0;
  logic hsEnd = 1'b0;
  vsfCfg_t drv;
  logic vsOut, fieldOut;
  logic [LINE_W-1:0] lineDbg;

  int genLen = PIX525;
  int gPix = 0;
  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit running = 0;
  bit done = 0;
  string curTag = "R10";

  always #2.5 clk = ~clk;

  vsf_gen #(
    .LINE_PIX_525(PIX525),
    .LINE_PIX_625(PIX625)
  ) u_vsf_gen (
    .clk(clk), .rstN(rstN), .std625(drv.std625),
    .hsBegin(hsBegin), .hsEnd(hsEnd),
    .progMode(drv.progMode), .refBegin(drv.refBegin),
    .begStartOdd(drv.begStartOdd), .begStartEven(drv.begStartEven),
    .endStartOdd(drv.endStartOdd), .endStartEven(drv.endStartEven),
    .invertVs(drv.invert),
    .vsBeg525(drv.beg525), .vsEnd525(drv.end525), .fldTog525(drv.fld525),
    .vsBeg625(drv.beg625), .vsEnd625(drv.end625), .fldTog625(drv.fld625),
    .vsOut(vsOut), .fieldOut(fieldOut), .lineDbg(lineDbg)
  );

  function automatic lineCtl_t mkCtl(int mag, bit neg, bit dOdd, bit dEven);
    lineCtl_t c;
    c.mag = 5'(mag); c.neg = neg; c.dlyOdd = dOdd; c.dlyEven = dEven;
    return c;
  endfunction

  // expected target line per R3 / R7
  function automatic int expTarget(bit prog, int nom, lineCtl_t c, bit useDly, int total);
    int t;
    if (!prog) return nom;
    t = nom + (c.neg ? -int'(c.mag) : int'(c.mag)) + (useDly ? 1 : 0);
    if (t < 1) t += total;
    if (t > total) t -= total;
    return t;
  endfunction

  // ---------------- line-accurate expectation ----------------
  int mLine, mPix;
  bit mVs, mFld;
  vsfCfg_t mAct;

  always @(posedge clk) begin
    if (!rstN) begin
      mLine = 0; mPix = 0; mVs = 0; mFld = 0; mAct = resetCfg();
    end else begin
      int total, half, nl, ln;
      int bO, bE, eO, eE, fO, fE;
      bit ls, mid, p, hitSet, hitClr;
      lineCtl_t cb, ce, cf;
      p     = mAct.progMode;
      total = mAct.std625 ? 625 : 525;
      half  = mAct.std625 ? PIX625 / 2 : PIX525 / 2;
      ls    = mAct.refBegin ? hsBegin : hsEnd;
      nl    = (mLine >= total) ? 1 : mLine + 1;
      mid   = !ls && (mPix == half) && (mLine != 0);
      ln    = ls ? nl : mLine;
      cb = mAct.std625 ? mAct.beg625 : mAct.beg525;
      ce = mAct.std625 ? mAct.end625 : mAct.end525;
      cf = mAct.std625 ? mAct.fld625 : mAct.fld525;
      bO = expTarget(p, mAct.std625 ? 623 : 1,   cb, cb.dlyOdd,  total);
      bE = expTarget(p, mAct.std625 ? 311 : 263, cb, cb.dlyEven, total);
      eO = expTarget(p, mAct.std625 ? 5   : 10,  ce, ce.dlyOdd,  total);
      eE = expTarget(p, mAct.std625 ? 318 : 272, ce, ce.dlyEven, total);
      fO = expTarget(p, mAct.std625 ? 1   : 4,   cf, cf.dlyOdd,  total);
      fE = expTarget(p, mAct.std625 ? 313 : 266, cf, cf.dlyEven, total);
      hitSet = (ln == bO && ((p && !mAct.begStartOdd)  ? mid : ls)) ||
               (ln == bE && ((p && !mAct.begStartEven) ? mid : ls));
      hitClr = (ln == eO && ((p && !mAct.endStartOdd)  ? mid : ls)) ||
               (ln == eE && ((p && !mAct.endStartEven) ? mid : ls));
      if (hitClr) mVs = 0;            // R11: end wins
      else if (hitSet) mVs = 1;
      if (ls && ln == fE) mFld = 1;
      else if (ls && ln == fO) mFld = 0;
      if (ls && nl == 1) mAct = drv;  // R9
      if (ls) begin mLine = nl; mPix = 0; end
      else if (mPix < 1000) mPix++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      if (fails <= 20)
        $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // marker generator
  initial begin
    drv = resetCfg();
    forever begin
      @(negedge clk);
      hsBegin = (gPix == 0);
      hsEnd   = (gPix == 2);
      gPix    = (gPix + 1 >= genLen) ? 0 : gPix + 1;
    end
  end

  // per-cycle comparison and watchdog
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        check(1'b0, "watchdog", "cycles", cycles, WATCHDOG);
        finishRun();
      end
      if (running) begin
        int eVs;
        eVs = int'(mVs ^ mAct.invert);
        if (vsOut !== 1'(eVs) || fieldOut !== mFld || int'(lineDbg) != mLine) begin
          if (vsOut !== 1'(eVs))
            check(1'b0, curTag, "vsOut", int'(vsOut), eVs);
          else if (fieldOut !== mFld)
            check(1'b0, "R6", "fieldOut", int'(fieldOut), int'(mFld));
          else
            check(1'b0, "R1", "lineDbg", int'(lineDbg), mLine);
        end else begin
          check(1'b1, curTag, "cycle", 0, 0);
        end
      end
    end
  end

  task automatic runScn(string tag, vsfCfg_t c, int len, int n);
    @(negedge clk);
    curTag = tag;
    drv    = c;
    genLen = len;
    repeat (n) @(negedge clk);
  endtask

  localparam int RUN525 = 6250 + 4200 + 100;
  localparam int RUN625 = 6250 * 2 + 100;

  initial begin
    vsfCfg_t c;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(vsOut == 1'b0,    "R10", "vsOut in reset",    int'(vsOut), 0);
    check(fieldOut == 1'b0, "R10", "fieldOut in reset", int'(fieldOut), 0);
    check(lineDbg == '0,    "R10", "lineDbg in reset",  int'(lineDbg), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(lineDbg == '0 && vsOut == 1'b0, "R10", "state after release", int'(lineDbg), 0);
    running = 1;

    // R4 / R5 defaults, 525 lines
    runScn("R4", resetCfg(), PIX525, RUN525);

    // R3: offsets, delays, flipped positions
    c = resetCfg();
    c.beg525 = mkCtl(3, 0, 1, 0);
    c.end525 = mkCtl(2, 1, 0, 1);
    c.fld525 = mkCtl(1, 0, 0, 1);
    c.begStartOdd = 1; c.begStartEven = 0; c.endStartOdd = 1; c.endStartEven = 0;
    runScn("R3", c, PIX525, RUN525);

    // R5: wrap below 1, large end offset, leading-marker reference
    c = resetCfg();
    c.refBegin = 1;
    c.beg525 = mkCtl(5, 1, 0, 0);
    c.end525 = mkCtl(31, 0, 1, 1);
    c.endStartEven = 1;
    runScn("R5", c, PIX525, RUN525);

    // R7: fixed mode ignores offsets, delays, positions
    c = resetCfg();
    c.progMode = 0;
    c.beg525 = mkCtl(7, 1, 1, 1);
    c.end525 = mkCtl(4, 0, 1, 0);
    c.fld525 = mkCtl(9, 0, 1, 1);
    c.begStartOdd = 1; c.begStartEven = 0; c.endStartOdd = 1;
    runScn("R7", c, PIX525, RUN525);

    // R8: inverted output
    c = resetCfg();
    c.invert = 1;
    runScn("R8", c, PIX525, RUN525);

    // R1: 625-line counting with leading-marker reference
    c = resetCfg();
    c.std625 = 1; c.refBegin = 1;
    runScn("R1", c, PIX625, RUN625);

    // R3: 625-line offsets with wrap above N
    c = resetCfg();
    c.std625 = 1;
    c.beg625 = mkCtl(3, 0, 0, 0);
    c.end625 = mkCtl(4, 1, 1, 0);
    c.fld625 = mkCtl(2, 1, 1, 1);
    runScn("R3", c, PIX625, RUN625);

    // R11: start and end on the same mid-line point of line 10
    c = resetCfg();
    c.beg525 = mkCtl(9, 0, 0, 0);
    runScn("R11", c, PIX525, RUN525);

    // R9: change settings part way through a frame
    runScn("R9", resetCfg(), PIX525, 2600);
    c = resetCfg();
    c.invert = 1;
    c.beg525 = mkCtl(6, 0, 0, 1);
    c.begStartOdd = 1;
    runScn("R9", c, PIX525, RUN525);

    // R2: mid-line placement in 625 timing, trailing-marker reference
    c = resetCfg();
    c.std625 = 1;
    c.begStartEven = 0;
    c.end625 = mkCtl(1, 0, 0, 1);
    runScn("R2", c, PIX625, RUN625);

    running = 0;
    finishRun();
  end
endmodule